// File: doc/BRIEF.md
# Temperature-Driven Fan PWM Controller

This block drives one cooling fan. A host writes a small set of configuration registers. In automatic mode the block takes one of several signed 8-bit temperature readings, in °C, each time a strobe marks a fresh sample, and turns it into a PWM duty code. The mapping uses three limits. Below the off limit the fan stops. Above the start limit the fan runs, beginning at a start duty given in percent and rising by a slope in percent per degree. Above the full-speed limit the fan runs at the maximum code. Between the off and start limits the fan keeps its last on/off state, which gives hysteresis. In software mode the host writes the duty code directly.

The duty is re-evaluated only when the temperature has moved by at least a programmed interval since the last evaluation. A new duty code reaches the output pin only at the start of a PWM period, so no partial pulse is ever produced. The PWM period is 2^DUTY_W ticks of a base clock. The base clock is divided from the system clock, and one of eight settings is selectable. The output polarity is programmable.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: Register 0 bit 7 selects the mode: 0 is software mode, where the duty code is taken from register 1 (low DUTY_W bits) and temperature strobes have no effect; 1 is automatic mode.
- R2: Register 0 bits [1:0] select the temperature input as input number minus one (0 = input 1, 2 = input 3); a value naming a missing input selects the last input.
- R3: Temperatures are compared signed against register 2 (off limit) and register 3 (start limit). Below the off limit the fan is off and the duty is 0. Above the start limit the fan is on. In between, the on/off state from the previous evaluation is kept.
- R4: While the fan is on and the temperature T is not above the full limit, the percentage is start_pct + slope*(T - start) for T above the start limit, and start_pct otherwise. The duty code is pct*MAX/100 with integer division, and MAX for pct >= 100 (MAX = 2^DUTY_W - 1).
- R5: A temperature above register 4 (full-speed limit) gives code MAX and switches the fan on, taking priority over the off limit. Register 4 resets to 127, so a reading of 127 does not count as above it.
- R6: The slope is 7 bits wide: bits [5:0] come from register 6 bits [5:0], and bit 6 comes from register 5 bit 7. Register 5 bits [6:0] hold start_pct.
- R7: The duty is re-evaluated on a strobe only when |T - T_last| >= register 7 bits [4:0]. The first strobe after reset or after any register write is always evaluated.
- R8: The PWM period is 2^DUTY_W base ticks. The output is active for as many ticks as the duty code. Code MAX keeps it active for the whole period, and code 0 keeps it inactive.
- R9: Register 8 bits [2:0] select one base tick every 1, 2, 4, 6, 8, 16, 32 or 940 system clocks (codes 0 to 7). The reset code is 5 for 7-bit duty and 4 for 8-bit duty.
- R10: Register 8 bit 3 is the polarity: 1 makes the output active-high, 0 makes it active-low. It resets to 0.
- R11: duty_out changes only at a PWM period boundary. After reset, duty_out is 0 and the output pin is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| temp_in | input | NUM_T*8 | Signed °C readings, input 1 in the low byte |
| temp_valid | input | 1 | Marks a fresh set of readings |
| pwm_out | output | 1 | Fan PWM pin |
| duty_out | output | DUTY_W | Duty code currently applied |

## Verification
The delicate coincidence is a temperature strobe that falls in the same cycle as a PWM period wrap. In that cycle the curve logic writes a new target while the output stage latches the target for the next period. The bench finds a period start from the rising pin, then fires strobes at offsets of 125, 126 and 127 clocks later, which straddles the wrap cycle. It then requires duty_out to settle on the value computed from the new reading within two periods, so that no update is lost or latched half-formed. A second coincidence, a register write in the same cycle as a strobe, is covered by the rule that a write forces the next evaluation.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_SWDUT = 4'd1;
  localparam logic [3:0] A_OFF   = 4'd2;
  localparam logic [3:0] A_START = 4'd3;
  localparam logic [3:0] A_FULL  = 4'd4;
  localparam logic [3:0] A_SDUTY = 4'd5;
  localparam logic [3:0] A_SLOPE = 4'd6;
  localparam logic [3:0] A_DELTA = 4'd7;
  localparam logic [3:0] A_PWM   = 4'd8;

  typedef struct packed {
    logic       auto_mode;
    logic [1:0] tsel;
    logic [7:0] sw_duty;
    logic [7:0] lim_off;
    logic [7:0] lim_start;
    logic [7:0] lim_full;
    logic [6:0] start_pct;
    logic [6:0] slope;
    logic [4:0] delta;
    logic [2:0] clksel;
    logic       pol;
  } cfg_t;
endpackage

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int DUTY_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output cfg_t       cfg
);
  localparam logic [2:0] CLK_RST = (DUTY_W == 8) ? 3'd4 : 3'd5;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg           <= '0;
      cfg.lim_full  <= 8'd127;
      cfg.clksel    <= CLK_RST;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          cfg.auto_mode <= wr_data[7];
          cfg.tsel      <= wr_data[1:0];
        end
        A_SWDUT: cfg.sw_duty   <= wr_data;
        A_OFF:   cfg.lim_off   <= wr_data;
        A_START: cfg.lim_start <= wr_data;
        A_FULL:  cfg.lim_full  <= wr_data;
        A_SDUTY: begin
          cfg.start_pct <= wr_data[6:0];
          cfg.slope[6]  <= wr_data[7];
        end
        A_SLOPE: cfg.slope[5:0] <= wr_data[5:0];
        A_DELTA: cfg.delta      <= wr_data[4:0];
        A_PWM: begin
          cfg.clksel <= wr_data[2:0];
          cfg.pol    <= wr_data[3];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpc_curve.sv
module fpc_curve
  import fpc_pkg::*;
#(
  parameter int DUTY_W = 7,
  parameter int NUM_T  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  cfg_t                      cfg,
  input  logic                      cfg_touch,
  input  logic [NUM_T*8-1:0]        temp_in,
  input  logic                      temp_valid,
  output logic                      eval_fire,
  output logic signed [7:0]         sel_temp,
  output logic [DUTY_W-1:0]         auto_duty
);
  localparam logic [DUTY_W-1:0] MAXC = '1;
  localparam int LAST = NUM_T - 1;

  logic              force_q;
  logic              on_q;
  logic signed [7:0] last_q;

  logic signed [8:0] dt, rs;
  logic [8:0]        mag;
  logic              delta_ok;
  logic              above_full, below_off, above_start, on_next;
  logic [7:0]        rise;
  logic [15:0]       ramp;
  logic [6:0]        pct;
  logic [15:0]       code;

  // input selection with clamp to last input
  always_comb begin
    sel_temp = $signed(temp_in[7:0]);
    for (int i = 0; i < NUM_T; i++) begin
      if (int'(cfg.tsel) == i || (i == LAST && int'(cfg.tsel) > LAST))
        sel_temp = $signed(temp_in[8*i +: 8]);
    end
  end

  // delta gate
  always_comb begin
    dt       = {sel_temp[7], sel_temp} - {last_q[7], last_q};
    mag      = dt[8] ? 9'(-dt) : 9'(dt);
    delta_ok = force_q || (mag >= {4'd0, cfg.delta});
    eval_fire = temp_valid && cfg.auto_mode && delta_ok;
  end

  // hysteresis and ramp
  always_comb begin
    above_full  = sel_temp > $signed(cfg.lim_full);
    below_off   = sel_temp < $signed(cfg.lim_off);
    above_start = sel_temp > $signed(cfg.lim_start);
    if (above_full)       on_next = 1'b1;
    else if (below_off)   on_next = 1'b0;
    else if (above_start) on_next = 1'b1;
    else                  on_next = on_q;

    rs   = {sel_temp[7], sel_temp} - {cfg.lim_start[7], cfg.lim_start};
    rise = above_start ? rs[7:0] : 8'd0;
    ramp = 16'(cfg.start_pct) + 16'(cfg.slope) * 16'(rise);

    if (above_full)              pct = 7'd100;
    else if (!on_next)           pct = 7'd0;
    else if (ramp >= 16'd100)    pct = 7'd100;
    else                         pct = ramp[6:0];

    if (pct >= 7'd100) code = 16'(MAXC);
    else               code = (16'(pct) * 16'(MAXC)) / 16'd100;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q   <= 1'b1;
      on_q      <= 1'b0;
      last_q    <= '0;
      auto_duty <= '0;
    end else begin
      if (eval_fire) begin
        on_q      <= on_next;
        last_q    <= sel_temp;
        auto_duty <= code[DUTY_W-1:0];
      end
      if (cfg_touch)      force_q <= 1'b1;
      else if (eval_fire) force_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fpc_pwm.sv
module fpc_pwm #(
  parameter int DUTY_W = 7,
  parameter int PRE_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        clksel,
  input  logic              pol,
  input  logic [DUTY_W-1:0] target,
  output logic              period_wrap,
  output logic [DUTY_W-1:0] duty_q,
  output logic              pwm_q
);
  localparam logic [DUTY_W-1:0] MAXC = '1;

  function automatic logic [PRE_W-1:0] div_of(input logic [2:0] s);
    case (s)
      3'd0:    div_of = PRE_W'(1);
      3'd1:    div_of = PRE_W'(2);
      3'd2:    div_of = PRE_W'(4);
      3'd3:    div_of = PRE_W'(6);
      3'd4:    div_of = PRE_W'(8);
      3'd5:    div_of = PRE_W'(16);
      3'd6:    div_of = PRE_W'(32);
      default: div_of = PRE_W'(940);
    endcase
  endfunction

  logic [PRE_W-1:0]  pre_q;
  logic [DUTY_W-1:0] cnt_q;
  logic              tick, active;

  always_comb begin
    tick        = pre_q >= (div_of(clksel) - PRE_W'(1));
    period_wrap = tick && (cnt_q == MAXC);
    active      = (duty_q == MAXC) || (cnt_q < duty_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      duty_q <= '0;
      pwm_q  <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick)        cnt_q  <= cnt_q + DUTY_W'(1);
      if (period_wrap) duty_q <= target;
      pwm_q <= active ? pol : ~pol;
    end
  end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fpc_pkg::*;
#(
  parameter int DUTY_W = 7,
  parameter int NUM_T  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [3:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [NUM_T*8-1:0]   temp_in,
  input  logic                 temp_valid,
  output logic                 pwm_out,
  output logic [DUTY_W-1:0]    duty_out
);
  cfg_t              cfg;
  logic              eval_fire;
  logic signed [7:0] sel_temp;
  logic [DUTY_W-1:0] auto_duty;
  logic [DUTY_W-1:0] target;
  logic              period_wrap;
  logic              pol;
  logic [7:0]        lim_off, lim_full;

  fpc_regs #(.DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  fpc_curve #(.DUTY_W(DUTY_W), .NUM_T(NUM_T)) u_curve (
    .clk(clk), .rst(rst), .cfg(cfg), .cfg_touch(wr_en),
    .temp_in(temp_in), .temp_valid(temp_valid),
    .eval_fire(eval_fire), .sel_temp(sel_temp), .auto_duty(auto_duty)
  );

  always_comb begin
    target   = cfg.auto_mode ? auto_duty : cfg.sw_duty[DUTY_W-1:0];
    pol      = cfg.pol;
    lim_off  = cfg.lim_off;
    lim_full = cfg.lim_full;
  end

  fpc_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst), .clksel(cfg.clksel), .pol(pol), .target(target),
    .period_wrap(period_wrap), .duty_q(duty_out), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/fan_pwm_ctrl_chk.sv
module fan_pwm_ctrl_chk #(
  parameter int DUTY_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              period_wrap,
  input logic [DUTY_W-1:0] duty_out,
  input logic              pwm_out,
  input logic              pol,
  input logic              eval_fire,
  input logic signed [7:0] sel_temp,
  input logic [7:0]        lim_off,
  input logic [7:0]        lim_full,
  input logic [DUTY_W-1:0] auto_duty
);
  localparam logic [DUTY_W-1:0] MAXC = '1;

  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !period_wrap |=> $stable(duty_out)); // R11

  AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    duty_out == MAXC |=> pwm_out == $past(pol)); // R8

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    duty_out == '0 |=> pwm_out == !$past(pol)); // R10

  AST_BELOW_OFF: assert property (@(posedge clk) disable iff (rst)
    (eval_fire && sel_temp < $signed(lim_off) && sel_temp <= $signed(lim_full))
      |=> auto_duty == '0); // R3

  AST_ABOVE_FULL: assert property (@(posedge clk) disable iff (rst)
    (eval_fire && sel_temp > $signed(lim_full)) |=> auto_duty == MAXC); // R5
endmodule

bind fan_pwm_ctrl fan_pwm_ctrl_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .period_wrap(period_wrap), .duty_out(duty_out),
  .pwm_out(pwm_out), .pol(pol), .eval_fire(eval_fire), .sel_temp(sel_temp),
  .lim_off(lim_off), .lim_full(lim_full), .auto_duty(auto_duty)
);

// File: tb/sim_fan_pwm_ctrl.sv
module sim_fan_pwm_ctrl;
  localparam int DUTY_W = 7;
  localparam int NUM_T  = 3;
  localparam int NVEC   = 11;
  // {temperature, expected duty code}; start 40, off 30, full 80, 20 %, 3 %/deg
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd20, 8'd0}, {8'd35, 8'd0}, {8'd45, 8'd44}, {8'd35, 8'd25},
    {8'd60, 8'd101}, {8'd80, 8'd127}, {8'd81, 8'd127}, {8'd29, 8'd0},
    {8'd39, 8'd0}, {8'd41, 8'd29}, {8'hF6, 8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NUM_T*8-1:0] temp_in = '0;
  logic temp_valid = 1'b0;
  logic pwm_out;
  logic [DUTY_W-1:0] duty_out;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fan_pwm_ctrl #(.DUTY_W(DUTY_W), .NUM_T(NUM_T)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .temp_in(temp_in), .temp_valid(temp_valid), .pwm_out(pwm_out),
    .duty_out(duty_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] t);
    @(negedge clk);
    temp_in[7:0] = t; temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) c++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    settle(3); rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    settle(2);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset duty", int'(duty_out), 0);
    check("R11 reset pin idle", int'(pwm_out), 1);

    // automatic configuration, base tick every clock, active high
    wr(4'd2, 8'd30); wr(4'd3, 8'd40); wr(4'd4, 8'd80);
    wr(4'd5, 8'd20); wr(4'd6, 8'd3);  wr(4'd7, 8'd0);
    wr(4'd8, 8'h08); wr(4'd0, 8'h80);
    for (int v = 0; v < NVEC; v++) begin
      strobe(VEC[v][15:8]);
      settle(300);
      check($sformatf("R3 R4 R5 vec%0d", v), int'(duty_out), int'(VEC[v][7:0]));
    end

    // R2: input 3 selected by code 2 and by clamped code 3
    temp_in = {8'd45, 8'd20, 8'd20};
    wr(4'd0, 8'h82); strobe(8'd20); settle(300);
    check("R2 sel input3", int'(duty_out), 44);
    temp_in[23:16] = 8'd60;
    wr(4'd0, 8'h83); strobe(8'd20); settle(300);
    check("R2 clamp sel", int'(duty_out), 101);

    // R6: slope bit 6 from start-duty register bit 7
    wr(4'd0, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'd0);
    strobe(8'd41); settle(300);
    check("R6 slope bit6", int'(duty_out), 81);

    // R7: delta interval 5
    wr(4'd5, 8'd20); wr(4'd6, 8'd3); wr(4'd7, 8'd5);
    strobe(8'd50); settle(300);
    check("R7 forced eval", int'(duty_out), 63);
    strobe(8'd53); settle(300);
    check("R7 small move ignored", int'(duty_out), 63);
    strobe(8'd55); settle(300);
    check("R7 move equal delta", int'(duty_out), 82);

    // R1: software mode, strobes ignored
    wr(4'd7, 8'd0); wr(4'd0, 8'h00); wr(4'd1, 8'd64); settle(300);
    check("R1 software duty", int'(duty_out), 64);
    strobe(8'd90); settle(300);
    check("R1 strobe ignored", int'(duty_out), 64);
    count_high(128, c);
    check("R8 high ticks 64", c, 64);

    // R10: polarity
    wr(4'd1, 8'd32); settle(300);
    count_high(128, c);
    check("R10 active high", c, 32);
    wr(4'd8, 8'h00); settle(4);
    count_high(128, c);
    check("R10 active low", c, 96);

    // R9: divide by 2 gives 256-clock period
    wr(4'd8, 8'h09); settle(600);
    count_high(256, c);
    check("R9 clksel1", c, 64);

    // R8: extremes
    wr(4'd8, 8'h08); wr(4'd1, 8'd127); settle(300);
    count_high(128, c);
    check("R8 max full on", c, 128);
    wr(4'd1, 8'd0); settle(300);
    count_high(128, c);
    check("R8 zero off", c, 0);

    // R5: full limit reset value and priority
    do_reset();
    check("R11 reset duty again", int'(duty_out), 0);
    temp_in = '0;
    wr(4'd8, 8'h08); wr(4'd2, 8'd30); wr(4'd3, 8'd40);
    wr(4'd5, 8'd10); wr(4'd6, 8'd0); wr(4'd0, 8'h80);
    strobe(8'd127); settle(300);
    check("R5 127 not above reset full", int'(duty_out), 12);
    wr(4'd2, 8'd100); wr(4'd4, 8'd50);
    strobe(8'd60); settle(300);
    check("R5 full beats off", int'(duty_out), 127);

    // strobe coinciding with the period wrap
    wr(4'd2, 8'd30); wr(4'd4, 8'd80); wr(4'd6, 8'd2);
    strobe(8'd45); settle(300);
    check("R4 slope2 base", int'(duty_out), 25);
    for (int k = 125; k <= 127; k++) begin
      logic [7:0] t;
      int exp;
      t   = (k == 125) ? 8'd50 : (k == 126) ? 8'd55 : 8'd60;
      exp = (k == 125) ? 38 : (k == 126) ? 50 : 63;
      while (pwm_out) @(negedge clk);
      while (!pwm_out) @(negedge clk);
      repeat (k) @(negedge clk);
      temp_in[7:0] = t; temp_valid = 1'b1;
      @(negedge clk);
      temp_valid = 1'b0;
      settle(300);
      check($sformatf("R11 R4 wrap offset %0d", k), int'(duty_out), exp);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule